// File: doc/BRIEF.md
# DDR Read Capture Path Without Data Strobe

This block takes read data from a double-data-rate memory bus and hands it to logic running on an unrelated system clock. Every data pin is sampled twice per cycle of a capture clock that a clock generator supplies at a tuned phase. The memory's read strobe plays no part: the block has no strobe input, so there is no preamble or postamble window to open, close or mask.

Per bit, one register samples the pin on the rising edge of the capture clock and a second on the falling edge. A third register moves the falling-edge sample onto the next rising edge, so both halves of a word are present on the same edge. A pair of synchronizing registers then holds the high and low halves of the word. A capture-side enable tags the cycles that carry read data, and only those words are written into a small Gray-pointer asynchronous FIFO. On the system side, words leave through a valid/ready handshake in the order they were captured. Each clock domain has its own synchronous reset, and either reset empties the FIFO.

Top module: `ddr_rdcap_top`

## Requirements
- R1: A word pairs a falling-edge sample with the rising-edge sample that follows it half a capture cycle later. The rising-edge sample appears on `rd_hi` and the falling-edge sample on `rd_lo`, bit for bit from `dq_pin`.
- R2: A word is produced only when `cap_en` is 1 at the rising capture edge that samples its high half. Data on the pin in cycles with `cap_en` at 0 never reaches the output.
- R3: Words reach the system side in capture order, with none lost, repeated or corrupted, whatever the ratio between the two clock frequencies (as long as nothing overflows).
- R4: A word is consumed at a rising `sys_clk` edge only when `rd_valid` and `rd_ready` are both 1. While `rd_valid` is 1 and `rd_ready` is 0, `rd_valid` stays 1 and `rd_hi`/`rd_lo` hold their values.
- R5: The FIFO holds `FIFO_DEPTH` words. A word captured while `FIFO_DEPTH` words are still unread is dropped, the stored words are unchanged, and `cap_ovf` goes to 1.
- R6: `cap_ovf` stays 1 until a reset in either domain reaches the capture side; draining the FIFO does not clear it.
- R7: While either reset is active, `rd_valid` is 0 and the FIFO is not full. Words stored before a reset are discarded, and `cap_ovf` returns to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cap_clk | input | 1 | Generated read-capture clock |
| cap_rst | input | 1 | Synchronous active-high reset, capture domain |
| dq_pin | input | DQ_W | DDR read data from the memory bus |
| cap_en | input | 1 | Marks the capture cycle whose rising edge completes a valid word |
| cap_ovf | output | 1 | Sticky flag: a word was dropped because the FIFO was full |
| sys_clk | input | 1 | System clock |
| sys_rst | input | 1 | Synchronous active-high reset, system domain |
| rd_valid | output | 1 | A captured word is present on rd_hi/rd_lo |
| rd_ready | input | 1 | Consumer accepts the word this cycle |
| rd_hi | output | DQ_W | Rising-edge half of the word |
| rd_lo | output | DQ_W | Falling-edge half of the word |

## Verification
The bench drives the pin with different values in the two halves of each cycle. If the halves were swapped, or if a falling sample were paired with the wrong rising edge, every word would fail to match its expected value. Words sent with the enable low carry distinct marker values, so a leak of an unenabled cycle shows up as an out-of-order word. A backpressure run with an irregular ready pattern checks that data is held steady while stalled and that no word is skipped. A fill past capacity checks that exactly the first `FIFO_DEPTH` words survive and that the overflow flag stays set after the drain. A reset of only the system domain while words are stored checks that the capture side is cleared as well and that no stale word reappears after release.

// File: rtl/ddr_rdcap_pkg.sv
package ddr_rdcap_pkg;

   localparam int unsigned FIFO_MIN_DEPTH = 8;
   localparam int unsigned SYNC_MIN_STAGES = 2;

   // binary to reflected Gray code, 32-bit container
   function automatic logic [31:0] bin2gray(input logic [31:0] b);
      return b ^ (b >> 1);
   endfunction

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/ddr_rdcap_bitslice.sv
// Three capture registers per data bit: rise sample, fall sample, fall realigned.
module ddr_rdcap_bitslice #(
   parameter int unsigned DQ_W = 8
) (
   input  logic            cap_clk,
   input  logic [DQ_W-1:0] dq_pin,
   output logic [DQ_W-1:0] rise_q,
   output logic [DQ_W-1:0] fall_q
);

   for (genvar b = 0; b < DQ_W; b++) begin : g_bit
      logic reg_rise;
      logic reg_fall;
      logic reg_align;

      always_ff @(posedge cap_clk) begin
         reg_rise <= dq_pin[b];
      end

      always_ff @(negedge cap_clk) begin
         reg_fall <= dq_pin[b];
      end

      always_ff @(posedge cap_clk) begin
         reg_align <= reg_fall;
      end

      assign rise_q[b] = reg_rise;
      assign fall_q[b] = reg_align;
   end

endmodule

// File: rtl/ddr_rdcap_pair.sv
// Synchronizing register pair plus the enable pipeline that tags each word.
module ddr_rdcap_pair #(
   parameter int unsigned DQ_W = 8,
   localparam int unsigned WORD_W = 2 * DQ_W
) (
   input  logic              cap_clk,
   input  logic              rst,
   input  logic [DQ_W-1:0]   rise_q,
   input  logic [DQ_W-1:0]   fall_q,
   input  logic              cap_en,
   output logic [WORD_W-1:0] word,
   output logic              word_v
);

   logic            en_q;
   logic [DQ_W-1:0] sync_hi;
   logic [DQ_W-1:0] sync_lo;

   // en_q lines up with the rise register capturing the high half
   always_ff @(posedge cap_clk) begin
      if (rst) begin
         en_q   <= 1'b0;
         word_v <= 1'b0;
      end else begin
         en_q   <= cap_en;
         word_v <= en_q;
      end
   end

   always_ff @(posedge cap_clk) begin
      sync_hi <= rise_q;
      sync_lo <= fall_q;
   end

   assign word = {sync_hi, sync_lo};

endmodule

// File: rtl/ddr_rdcap_sync.sv
// Multi-stage flop synchronizer with synchronous clear.
module ddr_rdcap_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   logic [W-1:0] chain [STAGES];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int i = 0; i < int'(STAGES); i++) chain[i] <= '0;
      end else begin
         chain[0] <= d;
         for (int i = 1; i < int'(STAGES); i++) chain[i] <= chain[i-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/ddr_rdcap_afifo.sv
// Asynchronous FIFO, Gray pointers, first-word-fall-through read port.
module ddr_rdcap_afifo #(
   parameter int unsigned DW          = 16,
   parameter int unsigned DEPTH       = 16,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned AW = $clog2(DEPTH),
   localparam int unsigned PW = AW + 1
) (
   input  logic          wclk,
   input  logic          wrst,
   input  logic          push,
   input  logic [DW-1:0] wdata,
   output logic          full,
   output logic          ovf,
   output logic [PW-1:0] wgray_o,
   input  logic          rclk,
   input  logic          rrst,
   input  logic          pop,
   output logic [DW-1:0] rdata,
   output logic          empty,
   output logic [PW-1:0] rgray_o
);

   logic [DW-1:0] mem [DEPTH];

   logic [PW-1:0] wbin, wgray, rgray_w;
   logic [PW-1:0] rbin, rgray, wgray_r;
   logic [PW-1:0] wbin_nx, rbin_nx;
   logic [31:0]   wg32, rg32;
   logic          full_raw, wr_ok, rd_ok;

   // ---------------- write domain ----------------
   assign wbin_nx  = wbin + PW'(1);
   assign wg32     = ddr_rdcap_pkg::bin2gray(32'(wbin_nx));
   assign full_raw = (wgray == {~rgray_w[PW-1:PW-2], rgray_w[PW-3:0]});
   assign full     = full_raw & ~wrst;
   assign wr_ok    = push & ~full_raw & ~wrst;

   always_ff @(posedge wclk) begin
      if (wrst) begin
         wbin  <= '0;
         wgray <= '0;
         ovf   <= 1'b0;
      end else begin
         if (wr_ok) begin
            wbin  <= wbin_nx;
            wgray <= wg32[PW-1:0];
         end
         if (push && full_raw) ovf <= 1'b1;
      end
   end

   always_ff @(posedge wclk) begin
      if (wr_ok) mem[wbin[AW-1:0]] <= wdata;
   end

   ddr_rdcap_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
      .clk (wclk),
      .rst (wrst),
      .d   (rgray),
      .q   (rgray_w)
   );

   // ---------------- read domain ----------------
   assign rbin_nx = rbin + PW'(1);
   assign rg32    = ddr_rdcap_pkg::bin2gray(32'(rbin_nx));
   assign empty   = rrst | (rgray == wgray_r);
   assign rd_ok   = pop & ~empty;

   always_ff @(posedge rclk) begin
      if (rrst) begin
         rbin  <= '0;
         rgray <= '0;
      end else if (rd_ok) begin
         rbin  <= rbin_nx;
         rgray <= rg32[PW-1:0];
      end
   end

   ddr_rdcap_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
      .clk (rclk),
      .rst (rrst),
      .d   (wgray),
      .q   (wgray_r)
   );

   assign rdata   = mem[rbin[AW-1:0]];
   assign wgray_o = wgray;
   assign rgray_o = rgray;

endmodule

// File: rtl/ddr_rdcap_top.sv
module ddr_rdcap_top #(
   parameter int unsigned DQ_W        = 8,
   parameter int unsigned FIFO_DEPTH  = 16,
   parameter int unsigned SYNC_STAGES = 2,
   localparam int unsigned WORD_W = 2 * DQ_W,
   localparam int unsigned PTR_W  = $clog2(FIFO_DEPTH) + 1
) (
   input  logic            cap_clk,
   input  logic            cap_rst,
   input  logic [DQ_W-1:0] dq_pin,
   input  logic            cap_en,
   output logic            cap_ovf,
   input  logic            sys_clk,
   input  logic            sys_rst,
   output logic            rd_valid,
   input  logic            rd_ready,
   output logic [DQ_W-1:0] rd_hi,
   output logic [DQ_W-1:0] rd_lo
);

   // ---------------- elaboration checks ----------------
   if (DQ_W < 1) begin : g_bad_width
      $error("ddr_rdcap_top: DQ_W must be at least 1");
   end
   if (!ddr_rdcap_pkg::is_pow2(FIFO_DEPTH) ||
       FIFO_DEPTH < ddr_rdcap_pkg::FIFO_MIN_DEPTH) begin : g_bad_depth
      $error("ddr_rdcap_top: FIFO_DEPTH must be a power of two, 8 or more");
   end
   if (SYNC_STAGES < ddr_rdcap_pkg::SYNC_MIN_STAGES) begin : g_bad_sync
      $error("ddr_rdcap_top: SYNC_STAGES must be 2 or more");
   end

   // ---------------- reset crossing ----------------
   logic cap_rst_in_sys, sys_rst_in_cap;
   logic rst_w_all, rst_r_all;

   ddr_rdcap_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rst_c2s (
      .clk (sys_clk),
      .rst (sys_rst),
      .d   (cap_rst),
      .q   (cap_rst_in_sys)
   );

   ddr_rdcap_sync #(.W(1), .STAGES(SYNC_STAGES)) u_rst_s2c (
      .clk (cap_clk),
      .rst (cap_rst),
      .d   (sys_rst),
      .q   (sys_rst_in_cap)
   );

   assign rst_w_all = cap_rst | sys_rst_in_cap;
   assign rst_r_all = sys_rst | cap_rst_in_sys;

   // ---------------- capture ----------------
   logic [DQ_W-1:0]   rise_q, fall_q;
   logic [WORD_W-1:0] s_word;
   logic              s_push;

   ddr_rdcap_bitslice #(.DQ_W(DQ_W)) u_slice (
      .cap_clk (cap_clk),
      .dq_pin  (dq_pin),
      .rise_q  (rise_q),
      .fall_q  (fall_q)
   );

   ddr_rdcap_pair #(.DQ_W(DQ_W)) u_pair (
      .cap_clk (cap_clk),
      .rst     (rst_w_all),
      .rise_q  (rise_q),
      .fall_q  (fall_q),
      .cap_en  (cap_en),
      .word    (s_word),
      .word_v  (s_push)
   );

   // ---------------- clock crossing ----------------
   logic              w_full, r_empty;
   logic [PTR_W-1:0]  w_gray, r_gray;
   logic [WORD_W-1:0] r_word;

   ddr_rdcap_afifo #(
      .DW          (WORD_W),
      .DEPTH       (FIFO_DEPTH),
      .SYNC_STAGES (SYNC_STAGES)
   ) u_fifo (
      .wclk    (cap_clk),
      .wrst    (rst_w_all),
      .push    (s_push),
      .wdata   (s_word),
      .full    (w_full),
      .ovf     (cap_ovf),
      .wgray_o (w_gray),
      .rclk    (sys_clk),
      .rrst    (rst_r_all),
      .pop     (rd_ready),
      .rdata   (r_word),
      .empty   (r_empty),
      .rgray_o (r_gray)
   );

   assign rd_valid = ~r_empty;
   assign rd_hi    = r_word[WORD_W-1:DQ_W];
   assign rd_lo    = r_word[DQ_W-1:0];

endmodule

// File: rtl/ddr_rdcap_chk.sv
module ddr_rdcap_chk #(
   parameter int unsigned DQ_W  = 8,
   parameter int unsigned PTR_W = 5
) (
   input logic             cap_clk,
   input logic             sys_clk,
   input logic             rst_w_all,
   input logic             rst_r_all,
   input logic             s_push,
   input logic             w_full,
   input logic             cap_ovf,
   input logic             rd_valid,
   input logic             rd_ready,
   input logic [DQ_W-1:0]  rd_hi,
   input logic [DQ_W-1:0]  rd_lo,
   input logic [PTR_W-1:0] w_gray,
   input logic [PTR_W-1:0] r_gray
);

   AST_HOLD_STALL: assert property (@(posedge sys_clk) disable iff (rst_r_all)
      (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_hi) && $stable(rd_lo))); // R4

   AST_OVF_ON_FULL: assert property (@(posedge cap_clk) disable iff (rst_w_all)
      (s_push && w_full) |=> cap_ovf); // R5

   AST_OVF_STICKY: assert property (@(posedge cap_clk) disable iff (rst_w_all)
      cap_ovf |=> cap_ovf); // R6

   AST_WPTR_GRAY: assert property (@(posedge cap_clk) disable iff (rst_w_all)
      $countones(w_gray ^ $past(w_gray)) <= 1); // R3

   AST_RPTR_GRAY: assert property (@(posedge sys_clk) disable iff (rst_r_all)
      $countones(r_gray ^ $past(r_gray)) <= 1); // R3

   always @(posedge sys_clk) begin
      if (rst_r_all) begin
         AST_RST_NO_VALID: assert (!rd_valid); // R7
      end
   end

   always @(posedge cap_clk) begin
      if (rst_w_all) begin
         AST_RST_NOT_FULL: assert (!w_full); // R7
      end
   end

endmodule

bind ddr_rdcap_top ddr_rdcap_chk #(.DQ_W(DQ_W), .PTR_W(PTR_W)) u_chk (
   .cap_clk   (cap_clk),
   .sys_clk   (sys_clk),
   .rst_w_all (rst_w_all),
   .rst_r_all (rst_r_all),
   .s_push    (s_push),
   .w_full    (w_full),
   .cap_ovf   (cap_ovf),
   .rd_valid  (rd_valid),
   .rd_ready  (rd_ready),
   .rd_hi     (rd_hi),
   .rd_lo     (rd_lo),
   .w_gray    (w_gray),
   .r_gray    (r_gray)
);

// File: tb/ddr_rdcap_top_tb.sv
`timescale 1ns/1ps
module ddr_rdcap_top_tb;

   localparam int unsigned DW    = 8;
   localparam int unsigned DEPTH = 16;
   localparam realtime     TS    = 8.0;    // 125 MHz system clock
   localparam realtime     TC    = 11.0;   // unrelated capture clock

   logic          cap_clk = 1'b0, sys_clk = 1'b0;
   logic          cap_rst = 1'b1, sys_rst = 1'b1;
   logic [DW-1:0] dq_pin = '0;
   logic          cap_en = 1'b0;
   logic          cap_ovf, rd_valid, rd_ready;
   logic [DW-1:0] rd_hi, rd_lo;

   always #(TC/2) cap_clk = ~cap_clk;
   always #(TS/2) sys_clk = ~sys_clk;

   ddr_rdcap_top #(.DQ_W(DW), .FIFO_DEPTH(DEPTH), .SYNC_STAGES(2)) u_dut (
      .cap_clk  (cap_clk),
      .cap_rst  (cap_rst),
      .dq_pin   (dq_pin),
      .cap_en   (cap_en),
      .cap_ovf  (cap_ovf),
      .sys_clk  (sys_clk),
      .sys_rst  (sys_rst),
      .rd_valid (rd_valid),
      .rd_ready (rd_ready),
      .rd_hi    (rd_hi),
      .rd_lo    (rd_lo)
   );

   int unsigned n_chk = 0, n_bad = 0, rx_cnt = 0;
   logic [2*DW-1:0] exp_q [$];
   int          rdy_mode = 1;      // 0 always ready, 1 never, 2 irregular
   logic [7:0]  lfsr = 8'hA5;
   bit          rst_window = 1'b1;
   bit          hold_pend = 1'b0;
   logic [2*DW-1:0] held_word;

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // Receiver: choose ready at the falling sys edge, then record the transfer
   // that the following rising edge performs.
   initial begin
      rd_ready = 1'b0;
      forever begin
         @(negedge sys_clk);
         if (hold_pend && !rst_window)
            chk(rd_valid && ({rd_hi, rd_lo} == held_word), "R4 stall hold",
                {15'd0, rd_valid, rd_hi, rd_lo}, {15'd0, 1'b1, held_word});
         case (rdy_mode)
            0: rd_ready = 1'b1;
            1: rd_ready = 1'b0;
            default: begin
               lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
               rd_ready = lfsr[0];
            end
         endcase
         hold_pend = rd_valid && !rd_ready;
         held_word = {rd_hi, rd_lo};
         if (rd_valid && rd_ready && !rst_window) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R3 unexpected word", {16'd0, rd_hi, rd_lo}, 32'd0);
            end else begin
               logic [2*DW-1:0] e;
               e = exp_q.pop_front();
               chk({rd_hi, rd_lo} == e, "R1/R3 word", {16'd0, rd_hi, rd_lo},
                   {16'd0, e});
            end
            rx_cnt++;
         end
      end
   end

   // One capture cycle: low half before the falling edge, high half and
   // enable before the next rising edge.
   task automatic send_word(input logic [DW-1:0] hi, input logic [DW-1:0] lo,
                            input bit en, input bit expect_it);
      @(posedge cap_clk);
      #(TC/4);
      dq_pin = lo;
      #(TC/2);
      dq_pin = hi;
      cap_en = en;
      if (expect_it) exp_q.push_back({hi, lo});
   endtask

   task automatic idle_cap(input int n);
      for (int i = 0; i < n; i++) begin
         @(posedge cap_clk);
         #(TC*3/4);
         cap_en = 1'b0;
         dq_pin = 8'hEE;
      end
   endtask

   task automatic wait_drain(input string req);
      for (int i = 0; i < 4000 && exp_q.size() != 0; i++) @(negedge sys_clk);
      repeat (20) @(negedge sys_clk);
      chk(exp_q.size() == 0, req, exp_q.size(), 0);
   endtask

   task automatic t_reset_state();
      repeat (6) @(negedge sys_clk);
      chk(rd_valid == 1'b0, "R7 valid low in reset", rd_valid, 0);
      @(negedge cap_clk);
      chk(cap_ovf == 1'b0, "R7 ovf clear in reset", cap_ovf, 0);
      @(negedge cap_clk) cap_rst = 1'b0;
      @(negedge sys_clk) sys_rst = 1'b0;
      repeat (10) @(negedge sys_clk);
      rst_window = 1'b0;
      chk(rd_valid == 1'b0, "R7 empty after reset", rd_valid, 0);
   endtask

   task automatic t_stream();
      int unsigned base = rx_cnt;
      rdy_mode = 0;
      for (int k = 0; k < 40; k++)
         send_word(8'(k * 7 + 3), 8'(~k ^ 8'h5A), 1'b1, 1'b1);
      idle_cap(2);
      wait_drain("R3 stream drained");
      chk(rx_cnt - base == 40, "R1 stream count", rx_cnt - base, 40);
   endtask

   task automatic t_enable_gaps();
      int unsigned base = rx_cnt;
      rdy_mode = 0;
      for (int k = 0; k < 30; k++) begin
         bit en = (k % 3) != 1;
         if (en) send_word(8'(8'h40 + k), 8'(8'h90 + k), 1'b1, 1'b1);
         else    send_word(8'hFF, 8'h00, 1'b0, 1'b0);   // marker that must not appear
      end
      idle_cap(2);
      wait_drain("R2 gaps drained");
      chk(rx_cnt - base == 20, "R2 only enabled words", rx_cnt - base, 20);
   endtask

   task automatic t_backpressure();
      int unsigned base = rx_cnt;
      rdy_mode = 2;
      for (int k = 0; k < 40; k++) begin
         send_word(8'(k * 13), 8'(k * 5 + 1), 1'b1, 1'b1);
         idle_cap(1);
      end
      idle_cap(2);
      wait_drain("R4 backpressure drained");
      chk(rx_cnt - base == 40, "R4 backpressure count", rx_cnt - base, 40);
   endtask

   task automatic t_overflow();
      int unsigned base = rx_cnt;
      rdy_mode = 1;
      repeat (4) @(negedge sys_clk);
      for (int k = 0; k < int'(DEPTH) + 3; k++)
         send_word(8'(8'hC0 + k), 8'(8'h20 + k), 1'b1, k < int'(DEPTH));
      idle_cap(8);
      @(negedge cap_clk);
      chk(cap_ovf == 1'b1, "R5 overflow flagged", cap_ovf, 1);
      chk(rd_valid == 1'b1, "R5 data held while full", rd_valid, 1);
      rdy_mode = 0;
      wait_drain("R5 first DEPTH words drained");
      chk(rx_cnt - base == DEPTH, "R5 exactly DEPTH kept", rx_cnt - base, DEPTH);
      send_word(8'h11, 8'h22, 1'b1, 1'b1);
      idle_cap(4);
      wait_drain("R6 post-drain word");
      @(negedge cap_clk);
      chk(cap_ovf == 1'b1, "R6 ovf sticky after drain", cap_ovf, 1);
   endtask

   task automatic t_reset_flush();
      int unsigned base;
      rdy_mode = 1;
      for (int k = 0; k < 5; k++) send_word(8'(8'hA0 + k), 8'(8'h0A + k), 1'b1, 1'b0);
      idle_cap(8);
      @(negedge sys_clk);
      chk(rd_valid == 1'b1, "R7 words stored before reset", rd_valid, 1);
      rst_window = 1'b1;
      @(negedge sys_clk) sys_rst = 1'b1;
      repeat (3) @(negedge sys_clk);
      chk(rd_valid == 1'b0, "R7 valid low during sys reset", rd_valid, 0);
      repeat (6) @(negedge cap_clk);
      chk(cap_ovf == 1'b0, "R7 ovf cleared by sys reset", cap_ovf, 0);
      @(negedge sys_clk) sys_rst = 1'b0;
      repeat (12) @(negedge sys_clk);
      base = rx_cnt;
      rst_window = 1'b0;
      rdy_mode = 0;
      repeat (20) @(negedge sys_clk);
      chk(rx_cnt == base, "R7 stale words discarded", rx_cnt - base, 0);
      for (int k = 0; k < 3; k++) send_word(8'(8'h70 + k), 8'(8'h07 + k), 1'b1, 1'b1);
      idle_cap(2);
      wait_drain("R7 traffic after reset");
      chk(rx_cnt - base == 3, "R7 count after reset", rx_cnt - base, 3);
   endtask

   initial begin
      fork
         begin
            t_reset_state();
            t_stream();
            t_enable_gaps();
            t_backpressure();
            t_overflow();
            t_reset_flush();
         end
         begin
            repeat (150000) @(posedge sys_clk);
            chk(1'b0, "watchdog expired", 0, 1);
         end
      join_any
      disable fork;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule